// File: doc/BRIEF.md
# Warm-Boot RAM CRC32 Checker

This block decides whether a region of on-chip RAM may be trusted for a warm boot. A single-cycle start request captures a start address, a byte count and a 32-bit execution word. The block then reads the region one byte per clock through a synchronous read port with one cycle of latency. It folds every byte into a CRC32 remainder, appends the four bytes of the execution word, and compares the finished CRC with a 32-bit expected value.

The expected value lives in a register that a bus master writes and can read back. That register is cleared only by the cold reset. The warm reset returns the sequencer to idle but keeps the expected value. When a check finishes, the block raises a one-cycle done pulse. A pass flag, valid in the same cycle, tells the boot flow whether booting from RAM may go ahead.

Top module: `wbcrc_validator`

## Requirements
- R1: The CRC uses generator 0x04C11DB7 with no reflection, each byte shifted in most significant bit first. The remainder is preset to 0xFFFFFFFF and inverted (XOR 0xFFFFFFFF) before comparison.
- R2: The CRC covers the RAM bytes at start address, start+1, … start+len−1 in that order. These are followed by the execution word as bits 7:0, 15:8, 23:16 and finally 31:24.
- R3: A read is requested (mem_rd_en high) in each of the len cycles after the start is accepted. The addresses step by one from the start address, and no address past start+len−1 is ever issued. The read data is consumed one cycle after its request.
- R4: A byte count of zero is legal. No RAM read is issued, and only the four execution-word bytes enter the CRC.
- R5: busy rises in the cycle after the start is accepted. done is a single-cycle pulse that appears len+6 cycles after acceptance (5 cycles when len is zero). busy falls in that same cycle.
- R6: pass is 1 exactly when the computed CRC equals the expected value, and 0 otherwise. It is valid with done, held until the next accepted start, and cleared by that start.
- R7: A start request while busy is ignored. The address, count and execution word captured at acceptance stay in use even if the inputs change.
- R8: A write strobe loads the expected-value register, and exp_crc reads it back. Only cold reset (por_n low) clears it to 0x0. A warm reset (rst_n low) leaves it unchanged.
- R9: Either reset asserts asynchronously and forces busy, done, pass and mem_rd_en low at once. Release is synchronised over two clock edges, so a start is first accepted on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low |
| por_n | input | 1 | Cold reset, active low; also resets the sequencer |
| cfg_we | input | 1 | Write strobe for the expected-value register |
| cfg_wdata | input | 32 | Write data for the expected-value register |
| exp_crc | output | 32 | Read-back of the expected-value register |
| start | input | 1 | Start request, accepted only when idle |
| base_addr | input | ADDR_W | First byte address of the region |
| byte_len | input | LEN_W | Number of region bytes |
| exec_word | input | 32 | Execution word appended after the region |
| mem_rd_en | output | 1 | RAM read request |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_rd_data | input | 8 | RAM read data, one cycle after the request |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | CRC matched the expected value |

## Verification
The embedded properties watch several behaviours on every cycle:
- the remainder preset,
- the single-cycle shape of done,
- consecutive read addresses,
- the absence of reads for a zero count,
- that the captured parameters stay stable when a start arrives while busy,
- that the expected value holds unless written.

Only the bench's scenarios can show the rest. That covers the CRC value itself, the byte order of the execution word, the exact completion latency and the pass/fail outcome. It also covers the difference between warm and cold reset on the stored value, and the two-edge reset release. These scenarios are checked against a behavioural model that predicts every output cycle by cycle.

// File: rtl/wbcrc_pkg.sv
package wbcrc_pkg;

  localparam int          CRC_W      = 32;
  localparam int          BYTE_W     = 8;
  localparam int          XBYTES     = CRC_W / BYTE_W;
  localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOROUT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MEM  = 3'd1,
    ST_WAIT = 3'd2,
    ST_EXEC = 3'd3,
    ST_CMP  = 3'd4
  } wb_state_e;

  // One byte folded into the remainder, MSB first, unreflected.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] rem,
                                                     input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = rem;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/wbcrc_rst_sync.sv
module wbcrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wbcrc_expect_reg.sv
module wbcrc_expect_reg
  import wbcrc_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             we_i,
  input  logic [CRC_W-1:0] wdata_i,
  output logic [CRC_W-1:0] value_o
);

  logic [CRC_W-1:0] val_q;
  logic [CRC_W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we_i) val_d = wdata_i;
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) val_q <= '0;
    else             val_q <= val_d;
  end

  assign value_o = val_q;

  // R8: without a write the stored value never moves
  p_hold_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !we_i |=> $stable(value_o));

endmodule

// File: rtl/wbcrc_engine.sv
module wbcrc_engine
  import wbcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              feed_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_d;
  logic             rem_en;

  assign rem_en = init_i | feed_i;

  always_comb begin
    if (init_i) rem_d = CRC_PRESET;
    else        rem_d = crc_fold_byte(rem_q, byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign crc_o = rem_q;

  // R1: every check starts from the all-ones preset
  p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_o == 32'hFFFF_FFFF));

endmodule

// File: rtl/wbcrc_seq.sv
module wbcrc_seq
  import wbcrc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CRC_W-1:0]  xword_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [CRC_W-1:0]  expect_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_o,
  output logic              feed_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);

  localparam int XIDX_W = $clog2(XBYTES);
  localparam logic [XIDX_W-1:0] XIDX_LAST = XIDX_W'(XBYTES - 1);

  wb_state_e          st_q,    st_d;
  logic [ADDR_W-1:0]  addr_q,  addr_d;
  logic [LEN_W-1:0]   left_q,  left_d;
  logic [XIDX_W-1:0]  xidx_q,  xidx_d;
  logic [CRC_W-1:0]   xword_q, xword_d;
  logic               done_q,  done_d;
  logic               pass_q,  pass_d;
  logic               rdv_q;
  logic               rd_en;
  logic               init;
  logic [BYTE_W-1:0]  xbyte;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    left_d  = left_q;
    xidx_d  = xidx_q;
    xword_d = xword_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    init    = 1'b0;
    rd_en   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          init    = 1'b1;
          addr_d  = base_i;
          left_d  = len_i;
          xword_d = xword_i;
          xidx_d  = '0;
          pass_d  = 1'b0;
          st_d    = (len_i == '0) ? ST_EXEC : ST_MEM;
        end
      end
      ST_MEM: begin
        rd_en  = 1'b1;
        addr_d = addr_q + ADDR_W'(1);
        left_d = left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) st_d = ST_WAIT;
      end
      ST_WAIT: st_d = ST_EXEC;
      ST_EXEC: begin
        xidx_d = xidx_q + XIDX_W'(1);
        if (xidx_q == XIDX_LAST) st_d = ST_CMP;
      end
      ST_CMP: begin
        done_d = 1'b1;
        pass_d = ((crc_i ^ CRC_XOROUT) == expect_i);
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      xidx_q  <= '0;
      xword_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      xidx_q  <= xidx_d;
      xword_q <= xword_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      rdv_q   <= rd_en;
    end
  end

  // execution word, least significant byte first
  assign xbyte   = BYTE_W'(xword_q >> {xidx_q, 3'b000});
  assign byte_o  = rdv_q ? rdata_i : xbyte;
  assign feed_o  = rdv_q | (st_q == ST_EXEC);
  assign init_o  = init;
  assign rd_en_o = rd_en;
  assign addr_o  = addr_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;

  // R3: back-to-back reads walk upward by one byte
  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R4: an empty region issues no read
  p_len0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && len_i == '0) |=> !rd_en);

  // R5: done never lasts two cycles
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a start while busy does not recapture the execution word
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_i) |=> $stable(xword_q));

endmodule

// File: rtl/wbcrc_validator.sv
module wbcrc_validator
  import wbcrc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       exp_crc,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [31:0]       exec_word,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  logic              warm_arst_n;
  logic              warm_srst_n;
  logic              cold_srst_n;
  logic              eng_init;
  logic              eng_feed;
  logic [BYTE_W-1:0] eng_byte;
  logic [CRC_W-1:0]  eng_crc;

  assign warm_arst_n = rst_n & por_n;

  wbcrc_rst_sync #(.STAGES(2)) i_warm_sync (
    .clk    (clk),
    .arst_n (warm_arst_n),
    .srst_n (warm_srst_n)
  );

  wbcrc_rst_sync #(.STAGES(2)) i_cold_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (cold_srst_n)
  );

  wbcrc_expect_reg i_expect (
    .clk        (clk),
    .cold_rst_n (cold_srst_n),
    .we_i       (cfg_we),
    .wdata_i    (cfg_wdata),
    .value_o    (exp_crc)
  );

  wbcrc_engine i_engine (
    .clk    (clk),
    .rst_n  (warm_srst_n),
    .init_i (eng_init),
    .feed_i (eng_feed),
    .byte_i (eng_byte),
    .crc_o  (eng_crc)
  );

  wbcrc_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_seq (
    .clk      (clk),
    .rst_n    (warm_srst_n),
    .start_i  (start),
    .base_i   (base_addr),
    .len_i    (byte_len),
    .xword_i  (exec_word),
    .rdata_i  (mem_rd_data),
    .crc_i    (eng_crc),
    .expect_i (exp_crc),
    .rd_en_o  (mem_rd_en),
    .addr_o   (mem_addr),
    .init_o   (eng_init),
    .feed_o   (eng_feed),
    .byte_o   (eng_byte),
    .busy_o   (busy),
    .done_o   (done),
    .pass_o   (pass)
  );

endmodule

// File: tb/test_wbcrc_validator.sv
module test_wbcrc_validator;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n, por_n, cfg_we, start;
  logic [31:0]       cfg_wdata, exec_word, exp_crc;
  logic [ADDR_W-1:0] base_addr, mem_addr;
  logic [LEN_W-1:0]  byte_len;
  logic              mem_rd_en, busy, done, pass;
  logic [7:0]        mem_rd_data;
  logic [7:0]        mem [256];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wbcrc_validator #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_wbcrc_validator (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .exp_crc(exp_crc), .start(start), .base_addr(base_addr), .byte_len(byte_len),
    .exec_word(exec_word), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .pass(pass)
  );

  // RAM model with one cycle of read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit-serial reference CRC over a byte list
  function automatic logic [31:0] ref_crc(input logic [7:0] msg[$]);
    logic [31:0] r;
    logic        t;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < msg.size(); k++)
      for (int b = 7; b >= 0; b--) begin
        t = r[31] ^ msg[k][b];
        r = r << 1;
        if (t) r = r ^ 32'h04C1_1DB7;
      end
    return r ^ 32'hFFFF_FFFF;
  endfunction

  task automatic write_exp(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 readback after write", exp_crc, v);
  endtask

  // one full check, compared with the model on every cycle
  task automatic run(input logic [15:0] b, input int n, input logic [31:0] xw,
                     input bit want_pass, input bit poke);
    logic [7:0]  q[$];
    logic [31:0] c;
    int          lat;
    for (int i = 0; i < n; i++) q.push_back(mem[8'(b + 16'(i))]);
    for (int i = 0; i < 4; i++) q.push_back(8'(xw >> (8 * i)));
    c = ref_crc(q);
    write_exp(want_pass ? c : (c ^ 32'h0000_0100));
    base_addr = b; byte_len = LEN_W'(n); exec_word = xw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = (n == 0) ? 5 : n + 6;
    for (int cyc = 0; cyc <= lat + 1; cyc++) begin
      chk("R5 busy", {31'd0, busy}, {31'd0, cyc < lat});
      chk("R5 done pulse", {31'd0, done}, {31'd0, cyc == lat});
      chk(n == 0 ? "R4 no read" : "R3 read enable", {31'd0, mem_rd_en}, {31'd0, cyc < n});
      if (cyc < n) chk("R3 address", {16'd0, mem_addr}, {16'd0, b + 16'(cyc)});
      if (cyc == lat) chk("R1/R2 pass result (R6)", {31'd0, pass}, {31'd0, want_pass});
      if (cyc < lat && cyc > 0) chk("R6 pass low while busy", {31'd0, pass}, 32'd0);
      if (poke && cyc == 1) begin
        start = 1'b1; base_addr = b ^ 16'h0055; byte_len = 3; exec_word = ~xw; // R7
      end else start = 1'b0;
      @(negedge clk);
    end
    chk("R6 pass held", {31'd0, pass}, {31'd0, want_pass});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s9[$];
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 9; i++) mem[8'h40 + i] = 8'h31 + 8'(i);
    s9 = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk("R1 model sanity", ref_crc(s9), 32'hFC89_1918);

    rst_n = 1'b0; por_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; start = 1'b0;
    base_addr = '0; byte_len = '0; exec_word = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset read", {31'd0, mem_rd_en}, 32'd0);
    chk("R8 cold reset value", exp_crc, 32'd0);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (3) @(negedge clk);

    run(16'h0040, 9, 32'h1234_5678, 1'b1, 1'b0);   // R1 known string region
    run(16'h0010, 0, 32'hDEAD_BEEF, 1'b1, 1'b0);   // R4 empty region
    run(16'h0003, 1, 32'h0000_00FF, 1'b1, 1'b0);   // R3 single byte
    run(16'h0020, 17, 32'hA1B2_C3D4, 1'b0, 1'b0);  // R6 mismatch
    run(16'h0080, 200, 32'h0F0F_F0F0, 1'b1, 1'b0); // R3 long, wraps model RAM index
    run(16'h0030, 12, 32'h5555_AAAA, 1'b1, 1'b1);  // R7 start while busy
    run(16'h0040, 9, 32'h7856_3412, 1'b1, 1'b0);   // R2 byte order of exec word

    // warm reset mid-check keeps the expected value
    write_exp(32'hA5A5_5A5A);
    base_addr = 16'h0000; byte_len = 40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async busy clear", {31'd0, busy}, 32'd0);
    chk("R9 async read clear", {31'd0, mem_rd_en}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 warm reset keeps value", exp_crc, 32'hA5A5_5A5A);
    byte_len = 0; start = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R9 release edge 1", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R9 release edge 2", {31'd0, busy}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R9 first accepted start", {31'd0, busy}, 32'd1);
    repeat (8) @(negedge clk);
    chk("R8 value after warm cycle", exp_crc, 32'hA5A5_5A5A);

    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 cold reset clears", exp_crc, 32'd0);
    run(16'h0005, 4, 32'hCAFE_0001, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule